// File: doc/BRIEF.md
# I2C Master Bit-Timing Generator

This block produces the master-side clock and data line timing for a two-wire I2C-style bus. It is driven by a system clock and configured by a small set of tap parameters: a multiplier, a base tap offset, a per-tap step, separate base offsets for the START and STOP holds, and tap counts for the clock and data paths. From these it works out the SCL period, the delay from a falling SCL edge to an SDA change, and the SCL hold times around START and STOP. It drives the pads as two open-drain enables: a 1 pulls the line low and a 0 releases it high.

A controller issues one command at a time over a valid/ready handshake: START (which becomes a repeated START when the bus is already owned), STOP, BIT (clock out one bit) and RELEASE (free the bus without a STOP). An outside shift register presents the bit to send on `tx_bit`. The block samples it at the moment SDA is allowed to change, which is a set delay after SCL falls. Commands are taken only while the bus is free or while the master is parked with SCL held low at the end of a low phase.

Top module: `i2c_bit_timer`

## Requirements
- R1: After a synchronous reset `scl_oe` and `sda_oe` are 0 (both lines released, 1 meaning driven low) and `cmd_ready` is 1.
- R2: A START taken while the bus is free drives `sda_oe` to 1 at the accepting edge and keeps SCL released for HS cycles, then drives SCL low. HS = MUL×(start_base + (scl_taps−1)×tap_step), raised to 1 if it comes out 0.
- R3: A BIT taken while parked releases SCL for H = P/2 cycles and then drives it low for L = P−H cycles, after which `cmd_ready` returns. P = MUL×2×(base_tap + (scl_taps−1)×tap_step + 2).
- R4: D cycles after each SCL falling edge that ends a START or a BIT, `sda_oe` takes the inverse of `tx_bit` sampled at that edge. D = MUL×(base_tap + (sda_taps−1)×tap_step + 3), clamped to L−1. SCL and SDA never change in the same cycle.
- R5: A STOP taken while parked drives `sda_oe` to 1 at once and holds SCL low for L cycles. It then releases SCL, releases SDA HS_stop = MUL×(stop_base + (scl_taps−1)×tap_step) cycles later (minimum 1), and returns to the free state.
- R6: A START taken while parked releases SDA and holds SCL low for L cycles, releases SCL for H cycles, drives SDA low, and then follows the START hold and the data change of R2 and R4.
- R7: A RELEASE taken while parked releases SDA at once and releases SCL L cycles later. The bus is then free.
- R8: While the bus is free, STOP, BIT and RELEASE are accepted and have no effect: both lines stay released and `cmd_ready` stays 1.
- R9: `cmd_op` codes are 0 START, 1 STOP, 2 BIT, 3 RELEASE. `cmd_ready` is 1 only when the bus is free or parked, and it falls in the cycle after a non-ignored command is accepted. While `cmd_ready` is 1 and nothing is accepted, neither line changes.
- R10: A multiplier of 0 acts as 1 and a tap count of 0 acts as 1. A tap count of 1 removes the tap_step term. The multiplier scales the whole bracketed sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mul | input | MUL_W | Multiplier (0 treated as 1) |
| cfg_base_tap | input | TAP_W | Base tap offset for the period and the data hold |
| cfg_tap_step | input | TAP_W | Clocks added per tap beyond the first |
| cfg_start_base | input | TAP_W | Base offset of the START hold |
| cfg_stop_base | input | TAP_W | Base offset of the STOP hold |
| cfg_scl_taps | input | TAP_W | Clock-path tap count |
| cfg_sda_taps | input | TAP_W | Data-path tap count |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code |
| cmd_ready | output | 1 | Command can be taken this cycle |
| tx_bit | input | 1 | Bit to place on SDA, from an outside shifter |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A phase counter loaded with a wrong length, or a sequencer in the wrong state, shows at the pads as a line edge at the wrong cycle or an edge that never comes. The scoreboard catches this at the first wrong edge, which is at most one bit period after the command. A wrong data-hold delay moves the SDA edge inside the low phase and is seen at that same edge. A stuck state keeps `cmd_ready` low and is caught when the command completion check comes due.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_STOP    = 2'd1,
    OP_BIT     = 2'd2,
    OP_RELEASE = 2'd3
  } bt_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,    // bus free, both lines released
    ST_SHOLD,   // SDA low, SCL high: START hold
    ST_LOW,     // SCL low phase with data change
    ST_PARK,    // SCL held low, waiting for a command
    ST_RSREL,   // repeated START: SDA released, SCL low
    ST_RSHIGH,  // repeated START: SCL high before SDA falls
    ST_BHIGH,   // bit: SCL high phase
    ST_PLOW,    // STOP: SDA low, SCL low
    ST_PHOLD,   // STOP: SCL high, SDA low hold
    ST_RLOW     // release: SDA free, SCL low
  } bt_state_e;

  function automatic int unsigned bt_len_width(int unsigned tap_w, int unsigned mul_w);
    return 2 * tap_w + mul_w + 3;
  endfunction

endpackage

// File: rtl/i2c_bt_calc.sv
module i2c_bt_calc #(
  parameter int TAP_W = 8,
  parameter int MUL_W = 4,
  parameter int LEN_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MUL_W-1:0] cfg_mul,
  input  logic [TAP_W-1:0] cfg_base_tap,
  input  logic [TAP_W-1:0] cfg_tap_step,
  input  logic [TAP_W-1:0] cfg_start_base,
  input  logic [TAP_W-1:0] cfg_stop_base,
  input  logic [TAP_W-1:0] cfg_scl_taps,
  input  logic [TAP_W-1:0] cfg_sda_taps,
  output logic [LEN_W-1:0] hi_len,
  output logic [LEN_W-1:0] lo_len,
  output logic [LEN_W-1:0] sdah_len,
  output logic [LEN_W-1:0] start_len,
  output logic [LEN_W-1:0] stop_len
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] mul_e, scl_m1, sda_m1, step;
  logic [LEN_W-1:0] scl_span, sda_span;
  logic [LEN_W-1:0] period, lo_c, sdah_raw, hs_raw, hp_raw;

  always_comb begin
    mul_e    = (cfg_mul == '0) ? ONE : LEN_W'(cfg_mul);
    scl_m1   = (cfg_scl_taps == '0) ? '0 : LEN_W'(cfg_scl_taps) - ONE;
    sda_m1   = (cfg_sda_taps == '0) ? '0 : LEN_W'(cfg_sda_taps) - ONE;
    step     = LEN_W'(cfg_tap_step);
    scl_span = scl_m1 * step;
    sda_span = sda_m1 * step;
    // multiplier applied after the bracketed sum
    period   = mul_e * ((LEN_W'(cfg_base_tap) + scl_span + LEN_W'(2)) << 1);
    lo_c     = period - (period >> 1);
    sdah_raw = mul_e * (LEN_W'(cfg_base_tap) + sda_span + LEN_W'(3));
    hs_raw   = mul_e * (LEN_W'(cfg_start_base) + scl_span);
    hp_raw   = mul_e * (LEN_W'(cfg_stop_base) + scl_span);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_len    <= ONE;
      lo_len    <= LEN_W'(2);
      sdah_len  <= ONE;
      start_len <= ONE;
      stop_len  <= ONE;
    end else begin
      hi_len    <= period >> 1;
      lo_len    <= lo_c;
      sdah_len  <= (sdah_raw > lo_c - ONE) ? lo_c - ONE : sdah_raw;
      start_len <= (hs_raw == '0) ? ONE : hs_raw;
      stop_len  <= (hp_raw == '0) ? ONE : hp_raw;
    end
  end

endmodule

// File: rtl/i2c_bt_dcnt.sv
module i2c_bt_dcnt #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/i2c_bt_seq.sv
module i2c_bt_seq
  import i2c_bt_pkg::*;
#(
  parameter int LEN_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  output logic             cmd_ready,
  input  logic             tx_bit,
  input  logic [LEN_W-1:0] hi_len,
  input  logic [LEN_W-1:0] lo_len,
  input  logic [LEN_W-1:0] sdah_len,
  input  logic [LEN_W-1:0] start_len,
  input  logic [LEN_W-1:0] stop_len,
  input  logic             ph_zero,
  input  logic             sd_zero,
  output logic             ph_load,
  output logic [LEN_W-1:0] ph_val,
  output logic             sd_load,
  output logic [LEN_W-1:0] sd_val,
  output logic             scl_oe,
  output logic             sda_oe
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  bt_state_e st, st_n;
  bt_op_e    op;
  logic      pend, pend_n, scl_n, sda_n, accept;

  assign op        = bt_op_e'(cmd_op);
  assign cmd_ready = (st == ST_IDLE) || (st == ST_PARK);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    st_n    = st;
    scl_n   = scl_oe;
    sda_n   = sda_oe;
    pend_n  = pend;
    ph_load = 1'b0;
    ph_val  = '0;
    sd_load = 1'b0;
    sd_val  = '0;
    unique case (st)
      ST_IDLE: begin
        if (accept && op == OP_START) begin
          st_n    = ST_SHOLD;
          sda_n   = 1'b1;
          ph_load = 1'b1;
          ph_val  = start_len - ONE;
        end
      end
      ST_SHOLD, ST_BHIGH: begin
        if (ph_zero) begin
          st_n    = ST_LOW;
          scl_n   = 1'b1;
          ph_load = 1'b1;
          ph_val  = lo_len - ONE;
          sd_load = 1'b1;
          sd_val  = sdah_len - ONE;
          pend_n  = 1'b1;
        end
      end
      ST_LOW: begin
        if (pend && sd_zero) begin
          sda_n  = ~tx_bit;
          pend_n = 1'b0;
        end
        if (ph_zero) st_n = ST_PARK;
      end
      ST_PARK: begin
        if (accept) begin
          ph_load = 1'b1;
          unique case (op)
            OP_START: begin
              st_n   = ST_RSREL;
              sda_n  = 1'b0;
              ph_val = lo_len - ONE;
            end
            OP_BIT: begin
              st_n   = ST_BHIGH;
              scl_n  = 1'b0;
              ph_val = hi_len - ONE;
            end
            OP_STOP: begin
              st_n   = ST_PLOW;
              sda_n  = 1'b1;
              ph_val = lo_len - ONE;
            end
            default: begin
              st_n   = ST_RLOW;
              sda_n  = 1'b0;
              ph_val = lo_len - ONE;
            end
          endcase
        end
      end
      ST_RSREL: begin
        if (ph_zero) begin
          st_n    = ST_RSHIGH;
          scl_n   = 1'b0;
          ph_load = 1'b1;
          ph_val  = hi_len - ONE;
        end
      end
      ST_RSHIGH: begin
        if (ph_zero) begin
          st_n    = ST_SHOLD;
          sda_n   = 1'b1;
          ph_load = 1'b1;
          ph_val  = start_len - ONE;
        end
      end
      ST_PLOW: begin
        if (ph_zero) begin
          st_n    = ST_PHOLD;
          scl_n   = 1'b0;
          ph_load = 1'b1;
          ph_val  = stop_len - ONE;
        end
      end
      ST_PHOLD: begin
        if (ph_zero) begin
          st_n  = ST_IDLE;
          sda_n = 1'b0;
        end
      end
      ST_RLOW: begin
        if (ph_zero) begin
          st_n  = ST_IDLE;
          scl_n = 1'b0;
        end
      end
      default: begin
        st_n  = ST_IDLE;
        scl_n = 1'b0;
        sda_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      pend   <= 1'b0;
    end else begin
      st     <= st_n;
      scl_oe <= scl_n;
      sda_oe <= sda_n;
      pend   <= pend_n;
    end
  end

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bt_pkg::*;
#(
  parameter int TAP_W = 8,
  parameter int MUL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MUL_W-1:0] cfg_mul,
  input  logic [TAP_W-1:0] cfg_base_tap,
  input  logic [TAP_W-1:0] cfg_tap_step,
  input  logic [TAP_W-1:0] cfg_start_base,
  input  logic [TAP_W-1:0] cfg_stop_base,
  input  logic [TAP_W-1:0] cfg_scl_taps,
  input  logic [TAP_W-1:0] cfg_sda_taps,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  output logic             cmd_ready,
  input  logic             tx_bit,
  output logic             scl_oe,
  output logic             sda_oe
);

  localparam int LEN_W = int'(bt_len_width(TAP_W, MUL_W));
  localparam int NCNT  = 2;  // 0: phase length, 1: data hold

  logic [LEN_W-1:0] hi_len, lo_len, sdah_len, start_len, stop_len;
  logic [NCNT-1:0]  c_load, c_zero;
  logic [LEN_W-1:0] c_val [NCNT];
  logic             ph_load, sd_load;
  logic [LEN_W-1:0] ph_val, sd_val;

  i2c_bt_calc #(.TAP_W(TAP_W), .MUL_W(MUL_W), .LEN_W(LEN_W)) u_calc (
    .clk(clk), .rst(rst),
    .cfg_mul(cfg_mul), .cfg_base_tap(cfg_base_tap), .cfg_tap_step(cfg_tap_step),
    .cfg_start_base(cfg_start_base), .cfg_stop_base(cfg_stop_base),
    .cfg_scl_taps(cfg_scl_taps), .cfg_sda_taps(cfg_sda_taps),
    .hi_len(hi_len), .lo_len(lo_len), .sdah_len(sdah_len),
    .start_len(start_len), .stop_len(stop_len)
  );

  assign c_load[0] = ph_load;
  assign c_load[1] = sd_load;
  assign c_val[0]  = ph_val;
  assign c_val[1]  = sd_val;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    i2c_bt_dcnt #(.W(LEN_W)) u_cnt (
      .clk(clk), .rst(rst),
      .load(c_load[g]), .load_val(c_val[g]), .zero(c_zero[g])
    );
  end

  i2c_bt_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
    .tx_bit(tx_bit),
    .hi_len(hi_len), .lo_len(lo_len), .sdah_len(sdah_len),
    .start_len(start_len), .stop_len(stop_len),
    .ph_zero(c_zero[0]), .sd_zero(c_zero[1]),
    .ph_load(ph_load), .ph_val(ph_val),
    .sd_load(sd_load), .sd_val(sd_val),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk
  import i2c_bt_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       cmd_ready,
  input logic       scl_oe,
  input logic       sda_oe
);

  logic free_bus, parked;
  assign free_bus = cmd_ready && !scl_oe && !sda_oe;
  assign parked   = cmd_ready && scl_oe;

  // R1: released lines and ready after reset
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!scl_oe && !sda_oe && cmd_ready));

  // R2: START on a free bus pulls SDA first, SCL stays up
  a_r2_start_sda_first: assert property (@(posedge clk) disable iff (rst)
    (free_bus && cmd_valid && cmd_op == OP_START) |=> (sda_oe && !scl_oe && !cmd_ready));

  // R4: the two lines never move in the same cycle
  a_r4_no_joint_edge: assert property (@(posedge clk) disable iff (rst)
    !$stable(scl_oe) |-> $stable(sda_oe));

  // R5: STOP drives SDA low while SCL stays low
  a_r5_stop_entry: assert property (@(posedge clk) disable iff (rst)
    (parked && cmd_valid && cmd_op == OP_STOP) |=> (sda_oe && scl_oe && !cmd_ready));

  // R7: RELEASE frees SDA while SCL stays low
  a_r7_release_entry: assert property (@(posedge clk) disable iff (rst)
    (parked && cmd_valid && cmd_op == OP_RELEASE) |=> (!sda_oe && scl_oe && !cmd_ready));

  // R8: non-START commands on a free bus leave it free
  a_r8_idle_ignore: assert property (@(posedge clk) disable iff (rst)
    (free_bus && cmd_valid && cmd_op != OP_START) |=> free_bus);

  // R9: lines hold while waiting for a command
  a_r9_hold_when_waiting: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && !cmd_valid) |=> ($stable(scl_oe) && $stable(sda_oe)));

endmodule

bind i2c_bit_timer i2c_bit_timer_chk u_chk (.*);

// File: tb/i2c_bit_timer_test.sv
`timescale 1ns/1ps
module i2c_bit_timer_test;

  localparam int TAP_W = 8;
  localparam int MUL_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [MUL_W-1:0] cfg_mul = '0;
  logic [TAP_W-1:0] cfg_base_tap = '0, cfg_tap_step = '0, cfg_start_base = '0;
  logic [TAP_W-1:0] cfg_stop_base = '0, cfg_scl_taps = '0, cfg_sda_taps = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic tx_bit = 1'b1;
  logic cmd_ready, scl_oe, sda_oe;

  i2c_bit_timer #(.TAP_W(TAP_W), .MUL_W(MUL_W)) uut (
    .clk(clk), .rst(rst),
    .cfg_mul(cfg_mul), .cfg_base_tap(cfg_base_tap), .cfg_tap_step(cfg_tap_step),
    .cfg_start_base(cfg_start_base), .cfg_stop_base(cfg_stop_base),
    .cfg_scl_taps(cfg_scl_taps), .cfg_sda_taps(cfg_sda_taps),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
    .tx_bit(tx_bit), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always #4 clk = ~clk;  // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { int k; bit s; bit d; int rq; } ev_t;
  ev_t q[$];

  // bench model of the lines and timing
  bit m_scl = 0, m_sda = 0, m_park = 0;
  int P, H, L, D, HS, HP, len_rq;

  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_BIT = 2'd2, C_REL = 2'd3;

  task automatic chk(input bit ok, input int rq, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic void ev(input int k, input bit s, input bit d, input int rq);
    ev_t e;
    if (s != m_scl || d != m_sda) begin
      e.k = k; e.s = s; e.d = d; e.rq = rq;
      q.push_back(e);
      m_scl = s; m_sda = d;
    end
  endfunction

  // R10: zero multiplier and zero tap counts act as one
  task automatic set_cfg(input int mul, input int base, input int step, input int sb,
                         input int pb, input int sct, input int sdt, input int rq);
    int me, sc, sd;
    @(negedge clk);
    cfg_mul = MUL_W'(mul); cfg_base_tap = TAP_W'(base); cfg_tap_step = TAP_W'(step);
    cfg_start_base = TAP_W'(sb); cfg_stop_base = TAP_W'(pb);
    cfg_scl_taps = TAP_W'(sct); cfg_sda_taps = TAP_W'(sdt);
    me = (mul == 0) ? 1 : mul;
    sc = ((sct == 0) ? 0 : sct - 1) * step;
    sd = ((sdt == 0) ? 0 : sdt - 1) * step;
    P  = me * 2 * (base + sc + 2);
    H  = P / 2;
    L  = P - H;
    D  = me * (base + sd + 3);
    if (D > L - 1) D = L - 1;
    HS = me * (sb + sc); if (HS == 0) HS = 1;
    HP = me * (pb + sc); if (HP == 0) HP = 1;
    len_rq = rq;
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input bit txb);
    int a, e, t0;
    bit ign;
    ign = !m_park && (op != C_START);
    tx_bit = txb;
    a = cyc + 1;
    e = a;
    if (!m_park) begin
      if (op == C_START) begin               // R2
        ev(a, 0, 1, 2);
        t0 = a + HS;
        ev(t0, 1, 1, 2);
        ev(t0 + D, 1, !txb, 4);
        e = t0 + L; m_park = 1;
      end
    end else begin
      unique case (op)
        C_BIT: begin                         // R3
          ev(a, 0, m_sda, 3);
          t0 = a + H;
          ev(t0, 1, m_sda, 3);
          ev(t0 + D, 1, !txb, 4);
          e = t0 + L;
        end
        C_START: begin                       // R6
          ev(a, 1, 0, 6);
          ev(a + L, 0, 0, 6);
          ev(a + L + H, 0, 1, 6);
          t0 = a + L + H + HS;
          ev(t0, 1, 1, 6);
          ev(t0 + D, 1, !txb, 4);
          e = t0 + L;
        end
        C_STOP: begin                        // R5
          ev(a, 1, 1, 5);
          ev(a + L, 0, 1, 5);
          ev(a + L + HP, 0, 0, 5);
          e = a + L + HP; m_park = 0;
        end
        default: begin                       // R7
          ev(a, 1, 0, 7);
          ev(a + L, 0, 0, 7);
          e = a + L; m_park = 0;
        end
      endcase
    end
    cmd_op = op; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (ign) begin
      // R8: ignored on a free bus
      chk(cmd_ready == 1'b1, 8, "ready after ignored command", int'(cmd_ready), 1);
      chk(!scl_oe && !sda_oe, 8, "lines after ignored command", int'({scl_oe, sda_oe}), 0);
    end else begin
      // R9: ready drops after acceptance
      chk(cmd_ready == 1'b0, 9, "ready after accept", int'(cmd_ready), 0);
      while (!cmd_ready) @(negedge clk);
      chk(cyc == e, (len_rq != 0) ? len_rq : ((op == C_BIT) ? 3 : 9),
          "command completion cycle", cyc, e);
    end
  endtask

  // monitor: every line change is compared against the queue
  initial begin
    bit ps = 0, pd = 0;
    ev_t x;
    forever begin
      @(negedge clk);
      if (!rst && (scl_oe != ps || sda_oe != pd)) begin
        if (q.size() == 0) begin
          chk(0, 4, "unexpected line change", int'({scl_oe, sda_oe}), int'({ps, pd}));
        end else begin
          x = q.pop_front();
          chk(cyc == x.k, x.rq, "edge cycle", cyc, x.k);
          chk(scl_oe == x.s && sda_oe == x.d, x.rq, "line levels",
              int'({scl_oe, sda_oe}), int'({x.s, x.d}));
        end
        ps = scl_oe; pd = sda_oe;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, 9, "watchdog: run did not finish", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!scl_oe && !sda_oe, 1, "lines in reset", int'({scl_oe, sda_oe}), 0);
    chk(cmd_ready == 1'b1, 1, "ready in reset", int'(cmd_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && cmd_ready, 1, "state after reset", int'({scl_oe, sda_oe, cmd_ready}), 1);

    // config A: no clamping, P=16 H=8 L=8 D=5 HS=7 HP=8
    set_cfg(1, 2, 2, 3, 4, 3, 1, 0);
    issue(C_STOP, 1);   // R8
    issue(C_BIT, 0);    // R8
    issue(C_REL, 1);    // R8
    issue(C_START, 1);  // R2, R4
    issue(C_BIT, 0);    // R3, R4
    issue(C_BIT, 1);
    issue(C_BIT, 1);
    issue(C_START, 0);  // R6
    issue(C_BIT, 1);
    issue(C_STOP, 1);   // R5
    issue(C_START, 0);
    issue(C_BIT, 1);
    issue(C_REL, 1);    // R7

    // config B (R10): multiplier 0, tap counts 1, zero hold bases; D clamped to L-1
    set_cfg(0, 1, 5, 0, 0, 1, 1, 10);
    issue(C_START, 1);
    issue(C_BIT, 0);
    issue(C_BIT, 1);
    issue(C_START, 1);
    issue(C_STOP, 0);

    // config C (R10): multiplier 3, tap counts 0
    set_cfg(3, 0, 1, 2, 1, 0, 0, 10);
    issue(C_START, 0);
    issue(C_BIT, 1);
    issue(C_BIT, 0);
    issue(C_REL, 0);
    issue(C_START, 1);
    issue(C_STOP, 1);

    repeat (5) @(negedge clk);
    chk(q.size() == 0, 4, "pending expected edges", q.size(), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule